// File: doc/BRIEF.md
# Flash Partition Command Sequencer

This block carries out a single partition command for a data-flash array. The command divides the array between two regions. One is a user region that software reads and writes directly. The other is a region that backs an emulated-EEPROM buffer RAM. Both sizes are counted in 256-byte sectors.

The host loads three command words into a small indexed bank. Word 0 holds the command code, which this block does not decode. Word 1 holds the data-flash sector count and word 2 holds the buffer-RAM sector count. The host then pulses `launch`. The sequencer checks five launch conditions. If every check passes, it writes each count twice into a four-word model of the nonvolatile information row. It then reads all four words back, grades any read trouble into two error bits and raises the completion flag. The command may succeed only once per reset. After it succeeds, the block gives the address just past the user region and the first address of the buffer-RAM region.

The controller has five named states:
- `ST_IDLE` moves to `ST_CHECK` when `launch` is seen.
- `ST_CHECK` moves to `ST_FINISH` when any launch error is found, and to `ST_PROG` otherwise.
- `ST_PROG` writes one word per cycle and moves to `ST_VERIFY` after row word 3.
- `ST_VERIFY` reads one word per cycle and moves to `ST_FINISH` after row word 3.
- `ST_FINISH` returns to `ST_IDLE`.

A successful command takes 10 clock edges from the launch edge to completion.

Top module: `part_cmd_seq`

## Requirements
- R1: After reset, all status flags are low, `part_defined` is low, both region addresses read 0, and all four row words read 16'hFFFF.
- R2: A valid launch writes the data-flash count to row word 0, then its duplicate to word 1, then the buffer-RAM count to word 2, then its duplicate to word 3. The writes occur one per cycle with the first at word 0. Afterwards `stat_done` and `part_defined` are high and `stat_acc_err` is low.
- R3: If the command index is not 3'b010 at launch, `stat_acc_err` is set and no row word changes.
- R4: If `ldf_active` is high during the check cycle, `stat_acc_err` is set and no row word changes.
- R5: If `mode_ok` is low during the check cycle, `stat_acc_err` is set and no row word changes.
- R6: Once `part_defined` is high, any later launch sets `stat_acc_err`, leaves the row unchanged and leaves `part_defined` high. No row write ever occurs while `part_defined` is high.
- R7: A data-flash count above 128 or a buffer-RAM count above 16 sets `stat_acc_err` with no write. Counts of exactly 128 and 16 are accepted.
- R8: `stat_prot_viol` stays low in every case.
- R9: During read-back, a correctable read problem (`inj_soft`) sets only `stat_rd_err`. A non-correctable problem (`inj_hard`) or a data mismatch sets both `stat_rd_err` and `stat_rd_fatal`. `stat_rd_fatal` is never high without `stat_rd_err`.
- R10: `stat_done` is low whenever `busy` is high. It rises when the command ends, whether it succeeded or failed, at the same edge that `busy` falls.
- R11: A launch clears all four flags. Writing 1 to a `flag_clr` bit clears one flag: bit 0 clears done, bit 1 clears access error, bit 2 clears read error and bit 3 clears fatal read error.
- R12: After success, `df_end_addr` equals 0x10_0000 + 256 × data-flash count and `er_base_addr` equals 0x14_0000 − 256 × buffer-RAM count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| obj_sel_we | input | 1 | Loads the command index |
| obj_sel | input | 3 | New command index |
| obj_data_we | input | 1 | Writes a word at the current index |
| obj_data | input | 16 | Command word |
| launch | input | 1 | Starts the command when idle |
| ldf_active | input | 1 | A load-data-field sequence is in progress |
| mode_ok | input | 1 | The command is allowed in the current mode |
| inj_soft | input | 1 | Model: correctable read problem during read-back |
| inj_hard | input | 1 | Model: non-correctable read problem during read-back |
| flag_clr | input | 4 | Write-1-to-clear strobes for the flags |
| row_raddr | input | 2 | Host read address into the information row |
| row_rdata | output | 16 | Information row word |
| busy | output | 1 | Command in progress |
| stat_done | output | 1 | Command complete |
| stat_acc_err | output | 1 | Access error |
| stat_prot_viol | output | 1 | Protection violation, always low |
| stat_rd_err | output | 1 | Read-back error of any kind |
| stat_rd_fatal | output | 1 | Non-correctable read-back error |
| part_defined | output | 1 | Partitions have been defined |
| df_end_addr | output | 24 | First address past the user data-flash region |
| er_base_addr | output | 24 | First address of the buffer-RAM region |

## Verification
Some rules are checked on every cycle:
- the done flag stays low while the block is busy;
- a fatal read-back flag never appears without the general read error;
- `part_defined` never falls;
- no row write happens once the partitions are defined;
- row writes start at word 0 and climb by one per cycle.

The bench's directed scenarios show the rest:
- which launch conditions stop the command;
- that the written values are the two counts and their duplicates;
- that the 128 and 16 limits are inclusive;
- how read problems are graded;
- that the flags clear;
- the region addresses.

// File: rtl/part_seq_pkg.sv
`timescale 1ns/1ps
package part_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_PROG,
        ST_VERIFY,
        ST_FINISH
    } seq_state_t;

    // One bit per launch check; any set bit aborts the command.
    typedef struct packed {
        logic bad_idx;
        logic ldf_busy;
        logic mode_bad;
        logic redefine;
        logic bad_sel;
    } launch_err_t;

    localparam int CLR_DONE  = 0;
    localparam int CLR_ACC   = 1;
    localparam int CLR_RDERR = 2;
    localparam int CLR_FATAL = 3;

endpackage

// File: rtl/part_launch_chk.sv
`timescale 1ns/1ps
module part_launch_chk
    import part_seq_pkg::*;
#(
    parameter int IDX_W      = 3,
    parameter int DATA_W     = 16,
    parameter int LAUNCH_IDX = 2,
    parameter int DF_MAX     = 128,
    parameter int ER_MAX     = 16
) (
    input  logic [IDX_W-1:0]  obj_idx,
    input  logic              ldf_active,
    input  logic              mode_ok,
    input  logic              defined,
    input  logic [DATA_W-1:0] df_cnt,
    input  logic [DATA_W-1:0] er_cnt,
    output launch_err_t       err,
    output logic              err_any
);

    always_comb begin
        err.bad_idx  = (obj_idx != IDX_W'(LAUNCH_IDX));
        err.ldf_busy = ldf_active;
        err.mode_bad = !mode_ok;
        err.redefine = defined;
        err.bad_sel  = (df_cnt > DATA_W'(DF_MAX)) || (er_cnt > DATA_W'(ER_MAX));
        err_any      = |err;
    end

endmodule

// File: rtl/part_info_row.sv
`timescale 1ns/1ps
module part_info_row #(
    parameter int DATA_W = 16,
    parameter int WORDS  = 4,
    localparam int AW    = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_en,
    input  logic [AW-1:0]     raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [AW-1:0]     raddr_b,
    output logic [DATA_W-1:0] rdata_b,
    input  logic              inj_soft,
    input  logic              inj_hard,
    output logic              rd_soft,
    output logic              rd_hard
);

    logic [DATA_W-1:0] word_v [WORDS];

    // Each word powers up erased (all ones).
    for (genvar g = 0; g < WORDS; g++) begin : g_word
        logic [DATA_W-1:0] word_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                word_q <= '1;
            else if (we && (waddr == AW'(g)))
                word_q <= wdata;
        end
        assign word_v[g] = word_q;
    end

    assign rdata_a = word_v[raddr_a];
    assign rdata_b = word_v[raddr_b];
    assign rd_soft = rd_en & inj_soft;
    assign rd_hard = rd_en & inj_hard;

endmodule

// File: rtl/part_cmd_seq.sv
`timescale 1ns/1ps
module part_cmd_seq
    import part_seq_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int IDX_W      = 3,
    parameter int ROW_WORDS  = 4,
    parameter int LAUNCH_IDX = 2,
    parameter int DF_MAX     = 128,
    parameter int ER_MAX     = 16,
    parameter int ADDR_W     = 24,
    parameter int SECT_SHIFT = 8,
    parameter logic [ADDR_W-1:0] DF_BASE = 24'h10_0000,
    parameter logic [ADDR_W-1:0] ER_END  = 24'h13_FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              obj_sel_we,
    input  logic [IDX_W-1:0]  obj_sel,
    input  logic              obj_data_we,
    input  logic [DATA_W-1:0] obj_data,
    input  logic              launch,
    input  logic              ldf_active,
    input  logic              mode_ok,
    input  logic              inj_soft,
    input  logic              inj_hard,
    input  logic [3:0]        flag_clr,
    input  logic [1:0]        row_raddr,
    output logic [DATA_W-1:0] row_rdata,
    output logic              busy,
    output logic              stat_done,
    output logic              stat_acc_err,
    output logic              stat_prot_viol,
    output logic              stat_rd_err,
    output logic              stat_rd_fatal,
    output logic              part_defined,
    output logic [ADDR_W-1:0] df_end_addr,
    output logic [ADDR_W-1:0] er_base_addr
);

    localparam int BANK_N  = LAUNCH_IDX + 1;
    localparam int DF_SLOT = LAUNCH_IDX - 1;
    localparam int ER_SLOT = LAUNCH_IDX;
    localparam int RA_W    = $clog2(ROW_WORDS);
    localparam logic [RA_W-1:0] LAST_PTR = RA_W'(ROW_WORDS - 1);
    localparam logic [ADDR_W-1:0] ER_TOP = ER_END + ADDR_W'(1);

    // ---------------- command-object bank ----------------
    logic [IDX_W-1:0]  obj_idx_q;
    logic [DATA_W-1:0] bank_q [BANK_N];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            obj_idx_q <= '0;
            for (int i = 0; i < BANK_N; i++) bank_q[i] <= '0;
        end else begin
            if (obj_sel_we) obj_idx_q <= obj_sel;
            if (obj_data_we && !busy) begin
                for (int i = 0; i < BANK_N; i++)
                    if (obj_idx_q == IDX_W'(i)) bank_q[i] <= obj_data;
            end
        end
    end

    logic [DATA_W-1:0] df_word, er_word;
    assign df_word = bank_q[DF_SLOT];
    assign er_word = bank_q[ER_SLOT];

    // ---------------- launch checks ----------------
    launch_err_t       chk_err;
    logic              chk_any;
    logic              defined_q;

    part_launch_chk #(
        .IDX_W(IDX_W), .DATA_W(DATA_W), .LAUNCH_IDX(LAUNCH_IDX),
        .DF_MAX(DF_MAX), .ER_MAX(ER_MAX)
    ) u_chk_launch (
        .obj_idx    (obj_idx_q),
        .ldf_active (ldf_active),
        .mode_ok    (mode_ok),
        .defined    (defined_q),
        .df_cnt     (df_word),
        .er_cnt     (er_word),
        .err        (chk_err),
        .err_any    (chk_any)
    );

    // ---------------- state register ----------------
    seq_state_t state_q, state_d;
    logic [RA_W-1:0] ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (launch) state_d = ST_CHECK;
            ST_CHECK:  state_d = chk_any ? ST_FINISH : ST_PROG;
            ST_PROG:   if (ptr_q == LAST_PTR) state_d = ST_VERIFY;
            ST_VERIFY: if (ptr_q == LAST_PTR) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // ---------------- information row ----------------
    logic              row_we;
    logic [RA_W-1:0]   row_waddr;
    logic [DATA_W-1:0] row_wdata;
    logic [DATA_W-1:0] vfy_data;
    logic              vfy_en, vfy_soft, vfy_hard, vfy_miss;

    // Words 0/1 hold the data-flash count, words 2/3 the buffer-RAM count.
    function automatic logic [DATA_W-1:0] row_value(input logic [RA_W-1:0] a,
                                                    input logic [DATA_W-1:0] df,
                                                    input logic [DATA_W-1:0] er);
        return a[RA_W-1] ? er : df;
    endfunction

    assign row_we    = (state_q == ST_PROG);
    assign row_waddr = ptr_q;
    assign row_wdata = row_value(ptr_q, df_word, er_word);
    assign vfy_en    = (state_q == ST_VERIFY);
    assign vfy_miss  = vfy_en && (vfy_data != row_value(ptr_q, df_word, er_word));

    part_info_row #(.DATA_W(DATA_W), .WORDS(ROW_WORDS)) u_row (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (row_we),
        .waddr    (row_waddr),
        .wdata    (row_wdata),
        .rd_en    (vfy_en),
        .raddr_a  (ptr_q),
        .rdata_a  (vfy_data),
        .raddr_b  (row_raddr),
        .rdata_b  (row_rdata),
        .inj_soft (inj_soft),
        .inj_hard (inj_hard),
        .rd_soft  (vfy_soft),
        .rd_hard  (vfy_hard)
    );

    // ---------------- outputs and datapath ----------------
    logic done_q, acc_q, rderr_q, fatal_q, abort_q, rb_err_q, rb_fatal_q;
    logic [DATA_W-1:0] df_keep_q, er_keep_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q     <= 1'b0;
            acc_q      <= 1'b0;
            rderr_q    <= 1'b0;
            fatal_q    <= 1'b0;
            abort_q    <= 1'b0;
            rb_err_q   <= 1'b0;
            rb_fatal_q <= 1'b0;
            defined_q  <= 1'b0;
            ptr_q      <= '0;
            df_keep_q  <= '0;
            er_keep_q  <= '0;
        end else begin
            if (flag_clr[CLR_DONE])  done_q  <= 1'b0;
            if (flag_clr[CLR_ACC])   acc_q   <= 1'b0;
            if (flag_clr[CLR_RDERR]) rderr_q <= 1'b0;
            if (flag_clr[CLR_FATAL]) fatal_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (launch) begin
                    done_q  <= 1'b0;
                    acc_q   <= 1'b0;
                    rderr_q <= 1'b0;
                    fatal_q <= 1'b0;
                    ptr_q   <= '0;
                end
                ST_CHECK: begin
                    ptr_q      <= '0;
                    rb_err_q   <= 1'b0;
                    rb_fatal_q <= 1'b0;
                    abort_q    <= chk_any;
                    if (chk_any) acc_q <= 1'b1;
                end
                ST_PROG: ptr_q <= (ptr_q == LAST_PTR) ? '0 : ptr_q + 1'b1;
                ST_VERIFY: begin
                    ptr_q      <= (ptr_q == LAST_PTR) ? '0 : ptr_q + 1'b1;
                    rb_err_q   <= rb_err_q | vfy_soft | vfy_hard | vfy_miss;
                    rb_fatal_q <= rb_fatal_q | vfy_hard | vfy_miss;
                end
                ST_FINISH: begin
                    done_q <= 1'b1;
                    if (!abort_q) begin
                        rderr_q   <= rb_err_q;
                        fatal_q   <= rb_fatal_q;
                        defined_q <= 1'b1;
                        df_keep_q <= df_word;
                        er_keep_q <= er_word;
                    end
                end
                default: ;
            endcase
        end
    end

    assign busy           = (state_q != ST_IDLE);
    assign stat_done      = done_q;
    assign stat_acc_err   = acc_q;
    assign stat_prot_viol = 1'b0;
    assign stat_rd_err    = rderr_q;
    assign stat_rd_fatal  = fatal_q;
    assign part_defined   = defined_q;
    assign df_end_addr    = defined_q ? DF_BASE + (ADDR_W'(df_keep_q) << SECT_SHIFT) : '0;
    assign er_base_addr   = defined_q ? ER_TOP - (ADDR_W'(er_keep_q) << SECT_SHIFT) : '0;

endmodule

// File: rtl/part_cmd_seq_chk.sv
`timescale 1ns/1ps
module part_cmd_seq_chk #(
    parameter int RA_W = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            stat_done,
    input logic            stat_rd_err,
    input logic            stat_rd_fatal,
    input logic            part_defined,
    input logic            row_we,
    input logic [RA_W-1:0] row_waddr
);

    AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !stat_done); // R10

    AST_FATAL_NEEDS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd_fatal |-> stat_rd_err); // R9

    AST_NO_REWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        row_we |-> !part_defined); // R6

    AST_DEFINED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(part_defined) |-> part_defined); // R6

    AST_WRITE_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(row_we) |-> (row_waddr == '0)); // R2

    AST_WRITE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (row_we && $past(row_we)) |-> (row_waddr == RA_W'($past(row_waddr) + 1'b1))); // R2

endmodule

bind part_cmd_seq part_cmd_seq_chk #(.RA_W(RA_W)) u_part_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy          (busy),
    .stat_done     (stat_done),
    .stat_rd_err   (stat_rd_err),
    .stat_rd_fatal (stat_rd_fatal),
    .part_defined  (part_defined),
    .row_we        (row_we),
    .row_waddr     (row_waddr)
);

// File: tb/sim_part_cmd_seq.sv
`timescale 1ns/1ps
module sim_part_cmd_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        obj_sel_we = 1'b0;
    logic [2:0]  obj_sel = '0;
    logic        obj_data_we = 1'b0;
    logic [15:0] obj_data = '0;
    logic        launch = 1'b0;
    logic        ldf_active = 1'b0;
    logic        mode_ok = 1'b1;
    logic        inj_soft = 1'b0;
    logic        inj_hard = 1'b0;
    logic [3:0]  flag_clr = '0;
    logic [1:0]  row_raddr = '0;
    logic [15:0] row_rdata;
    logic        busy, stat_done, stat_acc_err, stat_prot_viol;
    logic        stat_rd_err, stat_rd_fatal, part_defined;
    logic [23:0] df_end_addr, er_base_addr;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    part_cmd_seq u0 (
        .clk(clk), .rst_n(rst_n), .obj_sel_we(obj_sel_we), .obj_sel(obj_sel),
        .obj_data_we(obj_data_we), .obj_data(obj_data), .launch(launch),
        .ldf_active(ldf_active), .mode_ok(mode_ok), .inj_soft(inj_soft),
        .inj_hard(inj_hard), .flag_clr(flag_clr), .row_raddr(row_raddr),
        .row_rdata(row_rdata), .busy(busy), .stat_done(stat_done),
        .stat_acc_err(stat_acc_err), .stat_prot_viol(stat_prot_viol),
        .stat_rd_err(stat_rd_err), .stat_rd_fatal(stat_rd_fatal),
        .part_defined(part_defined), .df_end_addr(df_end_addr),
        .er_base_addr(er_base_addr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ldf_active = 1'b0; mode_ok = 1'b1; inj_soft = 1'b0; inj_hard = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic put_word(input logic [2:0] idx, input logic [15:0] val);
        obj_sel_we = 1'b1; obj_sel = idx;
        @(negedge clk);
        obj_sel_we = 1'b0; obj_data_we = 1'b1; obj_data = val;
        @(negedge clk);
        obj_data_we = 1'b0;
    endtask

    task automatic load_cmd(input logic [15:0] df, input logic [15:0] er);
        put_word(3'd0, 16'h0020);
        put_word(3'd1, df);
        put_word(3'd2, er);
    endtask

    task automatic fire();
        launch = 1'b1;
        @(negedge clk);
        launch = 1'b0;
        for (int i = 0; i < 40 && busy; i++) @(negedge clk);
    endtask

    task automatic chk_row(input string tag, input logic [15:0] w0, input logic [15:0] w1,
                           input logic [15:0] w2, input logic [15:0] w3);
        logic [15:0] exp [4];
        exp[0] = w0; exp[1] = w1; exp[2] = w2; exp[3] = w3;
        for (int i = 0; i < 4; i++) begin
            row_raddr = 2'(i);
            #1;
            chk($sformatf("%s word%0d", tag, i), 32'(row_rdata), 32'(exp[i]));
        end
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 done", 32'(stat_done), 0);
        chk("R1 accerr", 32'(stat_acc_err), 0);
        chk("R1 rderr", 32'({stat_rd_err, stat_rd_fatal}), 0);
        chk("R1 defined", 32'(part_defined), 0);
        chk("R1 addrs", 32'(df_end_addr | er_base_addr), 0);
        chk("R8 pviol reset", 32'(stat_prot_viol), 0);
        chk_row("R1 row", 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF);
    endtask

    task automatic t_good_and_redefine();
        do_reset();
        load_cmd(16'd64, 16'd8);
        launch = 1'b1;
        @(negedge clk);
        launch = 1'b0;
        chk("R10 busy after launch", 32'(busy), 1);
        chk("R10 done low while busy", 32'(stat_done), 0);
        for (int i = 0; i < 40 && busy; i++) @(negedge clk);
        chk("R10 done at end", 32'(stat_done), 1);
        chk("R2 no accerr", 32'(stat_acc_err), 0);
        chk("R2 defined", 32'(part_defined), 1);
        chk("R9 clean readback", 32'({stat_rd_err, stat_rd_fatal}), 0);
        chk("R8 pviol success", 32'(stat_prot_viol), 0);
        chk_row("R2 row", 16'd64, 16'd64, 16'd8, 16'd8);
        chk("R12 df end", 32'(df_end_addr), 32'h10_4000);
        chk("R12 er base", 32'(er_base_addr), 32'h13_F800);
        // second launch after success
        load_cmd(16'd10, 16'd2);
        fire();
        chk("R6 accerr", 32'(stat_acc_err), 1);
        chk("R6 done", 32'(stat_done), 1);
        chk("R6 still defined", 32'(part_defined), 1);
        chk("R8 pviol redefine", 32'(stat_prot_viol), 0);
        chk_row("R6 row kept", 16'd64, 16'd64, 16'd8, 16'd8);
        chk("R6 df end kept", 32'(df_end_addr), 32'h10_4000);
        // write-1-to-clear
        flag_clr = 4'b0011;
        @(negedge clk);
        flag_clr = 4'b0000;
        chk("R11 done cleared", 32'(stat_done), 0);
        chk("R11 accerr cleared", 32'(stat_acc_err), 0);
    endtask

    task automatic t_bad_idx();
        do_reset();
        load_cmd(16'd20, 16'd4);
        obj_sel_we = 1'b1; obj_sel = 3'd1;
        @(negedge clk);
        obj_sel_we = 1'b0;
        fire();
        chk("R3 accerr", 32'(stat_acc_err), 1);
        chk("R3 not defined", 32'(part_defined), 0);
        chk_row("R3 row", 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF);
    endtask

    task automatic t_ldf();
        do_reset();
        load_cmd(16'd20, 16'd4);
        ldf_active = 1'b1;
        fire();
        ldf_active = 1'b0;
        chk("R4 accerr", 32'(stat_acc_err), 1);
        chk("R4 not defined", 32'(part_defined), 0);
        chk_row("R4 row", 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF);
    endtask

    task automatic t_mode();
        do_reset();
        load_cmd(16'd20, 16'd4);
        mode_ok = 1'b0;
        fire();
        mode_ok = 1'b1;
        chk("R5 accerr", 32'(stat_acc_err), 1);
        chk_row("R5 row", 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF);
    endtask

    task automatic t_limits();
        do_reset();
        load_cmd(16'd129, 16'd0);
        fire();
        chk("R7 df 129 accerr", 32'(stat_acc_err), 1);
        chk("R8 pviol bad sel", 32'(stat_prot_viol), 0);
        chk_row("R7 row after df 129", 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF);
        load_cmd(16'd0, 16'd17);
        fire();
        chk("R7 er 17 accerr", 32'(stat_acc_err), 1);
        chk("R7 er 17 not defined", 32'(part_defined), 0);
        load_cmd(16'd128, 16'd16);
        fire();
        chk("R7 max accepted", 32'(stat_acc_err), 0);
        chk("R7 max defined", 32'(part_defined), 1);
        chk_row("R7 max row", 16'd128, 16'd128, 16'd16, 16'd16);
        chk("R12 df end max", 32'(df_end_addr), 32'h10_8000);
        chk("R12 er base max", 32'(er_base_addr), 32'h13_F000);
    endtask

    task automatic t_readback();
        do_reset();
        load_cmd(16'd5, 16'd3);
        inj_soft = 1'b1;
        fire();
        inj_soft = 1'b0;
        chk("R9 soft rderr", 32'(stat_rd_err), 1);
        chk("R9 soft fatal", 32'(stat_rd_fatal), 0);
        chk("R9 soft done", 32'(stat_done), 1);
        flag_clr = 4'b0100;
        @(negedge clk);
        flag_clr = 4'b0000;
        chk("R11 rderr cleared", 32'(stat_rd_err), 0);
        do_reset();
        load_cmd(16'd5, 16'd3);
        inj_hard = 1'b1;
        fire();
        inj_hard = 1'b0;
        chk("R9 hard rderr", 32'(stat_rd_err), 1);
        chk("R9 hard fatal", 32'(stat_rd_fatal), 1);
        chk_row("R9 row", 16'd5, 16'd5, 16'd3, 16'd3);
        flag_clr = 4'b1000;
        @(negedge clk);
        flag_clr = 4'b0000;
        chk("R11 fatal cleared", 32'(stat_rd_fatal), 0);
        chk("R11 rderr kept", 32'(stat_rd_err), 1);
    endtask

    initial begin
        t_reset();
        t_good_and_redefine();
        t_bad_idx();
        t_ldf();
        t_mode();
        t_limits();
        t_readback();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule